// File: doc/BRIEF.md
# Mode-banked register file with status save

This block holds the architectural integer registers of a processor core that runs in several operating modes. It has sixteen 32-bit registers. Some register indices reach a private physical copy depending on the current operating mode. It also holds the current status word and one saved-status word per exception mode. Two combinational read ports and one write port serve the execute stage. An exception-entry request switches the mode, saves the status and writes the return address into the target mode's link register, all at one clock edge.

Status writes are filtered. A flags-only write touches just the condition flags. A full write can also change the interrupt masks and the mode, but only from a privileged mode. The current mode is the mode field of the status word, and it is driven out together with the flags and the masks. All ports are plain level-sampled control and data pins. None of them takes part in a handshake, and no port can be held back: reads always answer in the same cycle, and every write or request is acted on at the next rising edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register copy reads 0, the flags are 0, both interrupt masks are 1, the mode is supervisor (10011), and every saved-status word is 0.
- R2: Read data is combinational from the index and the current mode. A register write takes effect at the next rising edge and can be read back after that edge.
- R3: Mode encodings are user 10000, system 11111, fiq 10001, irq 10010, supervisor 10011, abort 10111 and undefined 11011. Fiq has private copies of indices 8 to 14. Irq, supervisor, abort and undefined each have private copies of 13 and 14. Every other index, including 15, and all of user and system, share one copy. A write in one mode never changes a copy that another mode owns.
- R4: The status word places N, Z, C and V at bits 31 to 28, the irq mask at bit 7, the fiq mask at bit 6 and the mode at bits 4 to 0. All other bits read 0. The flags output is {N,Z,C,V}.
- R5: An exception request whose target is fiq, irq, supervisor, abort or undefined does the following at the next edge. It copies the prior status into the target's saved-status word, sets the mode to the target and sets the irq mask. It sets the fiq mask only for a fiq target. It leaves the flags unchanged.
- R6: On such an entry the target mode's copy of register 14 receives exc_pc + 4.
- R7: An exception request that targets user, system or an unknown encoding has no effect.
- R8: A flags-only status write changes bits 31 to 28 and nothing else, in any mode.
- R9: A full status write in a privileged mode (any mode except user) updates the flags, both masks and the mode. If the written mode field is not a known encoding, the mode keeps its old value.
- R10: In user mode a full status write acts as a flags-only write.
- R11: The saved-status output shows the current mode's saved word. In user and system modes it equals the current status.
- R12: When an exception entry is taken, any register write and status write in the same cycle are dropped. When no entry is taken, a register write and a status write in the same cycle both happen, and the register write uses the mode in force before the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Exception target mode |
| exc_pc | input | 32 | PC of the trapping instruction |
| sr_wr_en | input | 1 | Status write enable |
| sr_flags_only | input | 1 | 1: flags-only write, 0: full write |
| sr_wr_data | input | 32 | Status write data |
| cur_status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |
| flags | output | 4 | {N,Z,C,V} |
| irq_mask | output | 1 | Irq masked when 1 |
| fiq_mask | output | 1 | Fiq masked when 1 |
| cur_mode | output | 5 | Current mode |

## Verification
Read data is due in the same cycle as a change of index or mode. Register writes, status writes and exception entries are due exactly one rising edge after the cycle that presents them. The bench therefore drives each operation, lets one rising edge pass, and then compares at the following falling edge. At that point it compares every output and sweeps both read ports over all sixteen indices against a behavioural model that was advanced at that same edge.

// File: rtl/banked_pkg.sv
package banked_pkg;
  localparam int NREG    = 16;
  localparam int IDXW    = 4;
  localparam int MODEW   = 5;
  localparam int NSAVED  = 5;
  localparam int FIQ_LO  = 8;
  localparam int FIQ_HI  = 14;
  localparam int SP_IDX  = 13;
  localparam int LR_IDX  = 14;
  localparam int FIQ_BASE  = NREG;
  localparam int PAIR_BASE = FIQ_BASE + (FIQ_HI - FIQ_LO + 1);
  localparam int NSLOT     = PAIR_BASE + 2 * (NSAVED - 1);
  localparam int SLOTW     = $clog2(NSLOT);
  localparam int FLAG_HI   = 31;
  localparam int FLAG_LO   = 28;
  localparam int IMASK_BIT = 7;
  localparam int FMASK_BIT = 6;

  localparam logic [MODEW-1:0] MD_USR = 5'b10000;
  localparam logic [MODEW-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODEW-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODEW-1:0] MD_SVC = 5'b10011;
  localparam logic [MODEW-1:0] MD_ABT = 5'b10111;
  localparam logic [MODEW-1:0] MD_UND = 5'b11011;
  localparam logic [MODEW-1:0] MD_SYS = 5'b11111;

  function automatic logic has_saved(input logic [MODEW-1:0] m);
    return (m == MD_FIQ) || (m == MD_IRQ) || (m == MD_SVC) ||
           (m == MD_ABT) || (m == MD_UND);
  endfunction

  function automatic logic mode_known(input logic [MODEW-1:0] m);
    return has_saved(m) || (m == MD_USR) || (m == MD_SYS);
  endfunction

  function automatic logic [2:0] saved_slot(input logic [MODEW-1:0] m);
    case (m)
      MD_IRQ:  return 3'd1;
      MD_SVC:  return 3'd2;
      MD_ABT:  return 3'd3;
      MD_UND:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import banked_pkg::*;
(
  input  logic [MODEW-1:0] mode,
  input  logic [IDXW-1:0]  idx,
  output logic [SLOTW-1:0] slot
);
  logic [SLOTW-1:0] pair_base;
  logic             paired;

  always_comb begin
    paired    = 1'b1;
    pair_base = '0;
    case (mode)
      MD_IRQ:  pair_base = SLOTW'(PAIR_BASE);
      MD_SVC:  pair_base = SLOTW'(PAIR_BASE + 2);
      MD_ABT:  pair_base = SLOTW'(PAIR_BASE + 4);
      MD_UND:  pair_base = SLOTW'(PAIR_BASE + 6);
      default: paired = 1'b0;
    endcase
  end

  always_comb begin
    slot = SLOTW'(idx);
    if (mode == MD_FIQ && idx >= IDXW'(FIQ_LO) && idx <= IDXW'(FIQ_HI))
      slot = SLOTW'(FIQ_BASE) + SLOTW'(idx) - SLOTW'(FIQ_LO);
    else if (paired && (idx == IDXW'(SP_IDX) || idx == IDXW'(LR_IDX)))
      slot = pair_base + SLOTW'(idx) - SLOTW'(SP_IDX);
  end
endmodule

// File: rtl/reg_store.sv
module reg_store
  import banked_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NRD  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SLOTW-1:0]           wslot,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NRD-1:0][SLOTW-1:0]  rslot,
  output logic [NRD-1:0][XLEN-1:0]   rdata
);
  logic [XLEN-1:0] mem [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) mem[s] <= '0;
    end else if (we) begin
      mem[wslot] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[rslot[p]];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wslot)] == $past(wdata));
endmodule

// File: rtl/status_unit.sv
module status_unit
  import banked_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [MODEW-1:0] exc_mode,
  input  logic             sr_wr_en,
  input  logic             sr_flags_only,
  input  logic [XLEN-1:0]  sr_wr_data,
  output logic             exc_taken,
  output logic [XLEN-1:0]  cur_status,
  output logic [XLEN-1:0]  saved_status,
  output logic [3:0]       flags,
  output logic             irq_mask,
  output logic             fiq_mask,
  output logic [MODEW-1:0] mode
);
  logic [XLEN-1:0] saved_q [NSAVED];
  logic            priv;

  assign exc_taken = exc_req && has_saved(exc_mode);
  assign priv      = (mode != MD_USR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      irq_mask <= 1'b1;
      fiq_mask <= 1'b1;
      mode     <= MD_SVC;
      for (int s = 0; s < NSAVED; s++) saved_q[s] <= '0;
    end else if (exc_taken) begin
      saved_q[saved_slot(exc_mode)] <= cur_status;
      mode     <= exc_mode;
      irq_mask <= 1'b1;
      if (exc_mode == MD_FIQ) fiq_mask <= 1'b1;
    end else if (sr_wr_en) begin
      flags <= sr_wr_data[FLAG_HI:FLAG_LO];
      if (!sr_flags_only && priv) begin
        irq_mask <= sr_wr_data[IMASK_BIT];
        fiq_mask <= sr_wr_data[FMASK_BIT];
        if (mode_known(sr_wr_data[MODEW-1:0])) mode <= sr_wr_data[MODEW-1:0];
      end
    end
  end

  always_comb begin
    cur_status                  = '0;
    cur_status[FLAG_HI:FLAG_LO] = flags;
    cur_status[IMASK_BIT]       = irq_mask;
    cur_status[FMASK_BIT]       = fiq_mask;
    cur_status[MODEW-1:0]       = mode;
  end

  assign saved_status = has_saved(mode) ? saved_q[saved_slot(mode)] : cur_status;

  assert_entry_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (mode == $past(exc_mode)) && irq_mask && (flags == $past(flags)));
  assert_entry_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> saved_status == $past(cur_status));
  assert_entry_fiq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_mode == MD_FIQ) |=> fiq_mask);
  assert_bad_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_taken && !sr_wr_en) |=> $stable(cur_status));
  assert_flags_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && sr_flags_only && !exc_taken) |=>
      $stable(mode) && $stable(irq_mask) && $stable(fiq_mask));
  assert_bad_mode_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && !sr_flags_only && !exc_taken && !mode_known(sr_wr_data[MODEW-1:0]))
      |=> $stable(mode));
  assert_user_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_USR && !exc_taken) |=>
      (mode == MD_USR) && $stable(irq_mask) && $stable(fiq_mask));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [3:0]       rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             exc_req,
  input  logic [4:0]       exc_mode,
  input  logic [XLEN-1:0]  exc_pc,
  input  logic             sr_wr_en,
  input  logic             sr_flags_only,
  input  logic [XLEN-1:0]  sr_wr_data,
  output logic [XLEN-1:0]  cur_status,
  output logic [XLEN-1:0]  saved_status,
  output logic [3:0]       flags,
  output logic             irq_mask,
  output logic             fiq_mask,
  output logic [4:0]       cur_mode
);
  localparam int NLOOK = 4;
  localparam int NRD   = 2;

  logic                         exc_taken;
  logic [NLOOK-1:0][MODEW-1:0]  look_mode;
  logic [NLOOK-1:0][IDXW-1:0]   look_idx;
  logic [NLOOK-1:0][SLOTW-1:0]  look_slot;
  logic [NRD-1:0][SLOTW-1:0]    rslot;
  logic [NRD-1:0][XLEN-1:0]     rdata;
  logic                         st_we;
  logic [SLOTW-1:0]             st_wslot;
  logic [XLEN-1:0]              st_wdata;

  // lookups: 0 read A, 1 read B, 2 write, 3 link of exception target
  assign look_mode = {exc_mode, cur_mode, cur_mode, cur_mode};
  assign look_idx  = {IDXW'(LR_IDX), wr_idx, rd_b_idx, rd_a_idx};

  for (genvar l = 0; l < NLOOK; l++) begin : g_look
    bank_map i_map (
      .mode (look_mode[l]),
      .idx  (look_idx[l]),
      .slot (look_slot[l])
    );
  end

  status_unit #(.XLEN(XLEN)) i_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_req       (exc_req),
    .exc_mode      (exc_mode),
    .sr_wr_en      (sr_wr_en),
    .sr_flags_only (sr_flags_only),
    .sr_wr_data    (sr_wr_data),
    .exc_taken     (exc_taken),
    .cur_status    (cur_status),
    .saved_status  (saved_status),
    .flags         (flags),
    .irq_mask      (irq_mask),
    .fiq_mask      (fiq_mask),
    .mode          (cur_mode)
  );

  assign st_we    = exc_taken || wr_en;
  assign st_wslot = exc_taken ? look_slot[3] : look_slot[2];
  assign st_wdata = exc_taken ? (exc_pc + XLEN'(4)) : wr_data;
  assign rslot    = {look_slot[1], look_slot[0]};

  reg_store #(.XLEN(XLEN), .NRD(NRD)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .wslot (st_wslot),
    .wdata (st_wdata),
    .rslot (rslot),
    .rdata (rdata)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];

  assert_mode_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_known(cur_mode));
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, exc_pc = '0, sr_wr_data = '0;
  logic        wr_en = 1'b0, exc_req = 1'b0, sr_wr_en = 1'b0, sr_flags_only = 1'b0;
  logic [4:0]  exc_mode = '0, cur_mode;
  logic [31:0] cur_status, saved_status;
  logic [3:0]  flags;
  logic        irq_mask, fiq_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_usr [16];
  logic [31:0] m_fiq [16];
  logic [31:0] m_pair [4][2];
  logic [31:0] m_saved [5];
  logic [31:0] m_cpsr;

  always #5 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_req(exc_req), .exc_mode(exc_mode), .exc_pc(exc_pc),
    .sr_wr_en(sr_wr_en), .sr_flags_only(sr_flags_only), .sr_wr_data(sr_wr_data),
    .cur_status(cur_status), .saved_status(saved_status), .flags(flags),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask), .cur_mode(cur_mode)
  );

  function automatic int pair_of(logic [4:0] m);
    case (m) IRQ: return 0; SVC: return 1; ABT: return 2; UND: return 3;
      default: return -1; endcase
  endfunction

  function automatic int saved_of(logic [4:0] m);
    if (m == FIQ) return 0;
    if (pair_of(m) >= 0) return pair_of(m) + 1;
    return -1;
  endfunction

  function automatic bit known(logic [4:0] m);
    return saved_of(m) >= 0 || m == USR || m == SYS;
  endfunction

  function automatic logic [31:0] mread(logic [4:0] m, int idx);
    if (m == FIQ && idx >= 8 && idx <= 14) return m_fiq[idx];
    if ((idx == 13 || idx == 14) && pair_of(m) >= 0) return m_pair[pair_of(m)][idx-13];
    return m_usr[idx];
  endfunction

  task automatic mwrite(logic [4:0] m, int idx, logic [31:0] d);
    if (m == FIQ && idx >= 8 && idx <= 14) m_fiq[idx] = d;
    else if ((idx == 13 || idx == 14) && pair_of(m) >= 0) m_pair[pair_of(m)][idx-13] = d;
    else m_usr[idx] = d;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [4:0] m = m_cpsr[4:0];
    chk("R4 status", cur_status, m_cpsr);
    chk("R4 flags", {28'd0, flags}, {28'd0, m_cpsr[31:28]});
    chk("R5 masks", {30'd0, irq_mask, fiq_mask}, {30'd0, m_cpsr[7:6]});
    chk("R9 mode", {27'd0, cur_mode}, {27'd0, m});
    chk("R11 saved", saved_status, saved_of(m) >= 0 ? m_saved[saved_of(m)] : m_cpsr);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i);
      rd_b_idx = 4'(15 - i);
      #0.2;
      chk("R3 read A", rd_a_data, mread(m, i));
      chk("R2 read B", rd_b_data, mread(m, 15 - i));
    end
  endtask

  task automatic step(bit ex, logic [4:0] em, logic [31:0] pc, bit we, int wi,
                      logic [31:0] wd, bit sw, bit sf, logic [31:0] sd);
    logic [4:0] old;
    exc_req = ex; exc_mode = em; exc_pc = pc;
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sr_wr_en = sw; sr_flags_only = sf; sr_wr_data = sd;
    @(posedge clk);
    old = m_cpsr[4:0];
    if (ex && saved_of(em) >= 0) begin
      m_saved[saved_of(em)] = m_cpsr;
      m_cpsr[4:0] = em;
      m_cpsr[7] = 1'b1;
      if (em == FIQ) m_cpsr[6] = 1'b1;
      mwrite(em, 14, pc + 32'd4);
    end else begin
      if (we) mwrite(old, wi, wd);
      if (sw) begin
        m_cpsr[31:28] = sd[31:28];
        if (!sf && old != USR) begin
          m_cpsr[7:6] = sd[7:6];
          if (known(sd[4:0])) m_cpsr[4:0] = sd[4:0];
        end
      end
    end
    #1;
    exc_req = 0; wr_en = 0; sr_wr_en = 0;
    @(negedge clk);
    check_all();
  endtask

  task automatic wreg(int i, logic [31:0] d); step(0, 0, 0, 1, i, d, 0, 0, 0); endtask
  task automatic swr(bit f, logic [31:0] d);  step(0, 0, 0, 0, 0, 0, 1, f, d); endtask
  task automatic enter(logic [4:0] m, logic [31:0] pc); step(1, m, pc, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] pool [9];
    pool = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b10101, 5'b00000};
    for (int i = 0; i < 16; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end
    for (int i = 0; i < 4; i++) begin m_pair[i][0] = '0; m_pair[i][1] = '0; end
    for (int i = 0; i < 5; i++) m_saved[i] = '0;
    m_cpsr = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    check_all();                       // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) wreg(i, 32'h1000_0000 + i);  // R2 svc writes
    swr(0, 32'h0000_001F);             // R9 privileged switch to system
    wreg(13, 32'hAAAA_0013); wreg(14, 32'hAAAA_0014); wreg(8, 32'h0000_0088);
    enter(IRQ, 32'h0000_0100);         // R5 R6
    wreg(13, 32'hBBBB_0013);
    enter(FIQ, 32'h0000_0200);         // R5 fiq mask, R3 fiq bank
    for (int i = 8; i < 15; i++) wreg(i, 32'h0000_00F0 + i);
    swr(0, 32'hA000_0010);             // to user
    swr(1, 32'h5000_0000);             // R8
    swr(0, 32'h0000_00D3);             // R10 user full write
    enter(USR, 32'h10); enter(5'b10101, 32'h20); enter(SYS, 32'h30); // R7
    enter(UND, 32'h0000_0300); enter(ABT, 32'h0000_0400); enter(SVC, 32'h0000_0500);
    step(1, IRQ, 32'h600, 1, 3, 32'hDEAD, 1, 0, 32'hF000_00DF);  // R12 drop
    swr(0, 32'h3000_0015);             // R9 unknown mode kept
    step(0, 0, 0, 1, 13, 32'h1313, 1, 0, 32'h0000_001F);         // R12 order
    for (int k = 0; k < 300; k++) begin
      step($urandom_range(0, 5) == 0, pool[$urandom_range(0, 8)], $urandom,
           $urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule